// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This block paints a small two-bit-per-pixel cursor image over a stream of display pixels. Each incoming beat carries the beam coordinates and the colour of the pixel underneath. The block decides whether that pixel falls inside the cursor box. If it does, it fetches the pixel's two-bit code from an internal pattern store. Depending on the display mode, it then emits one of three programmed cursor colours, the underlying colour unchanged, or the bitwise complement of the underlying colour.

A host programs the block through a byte-wide register port. This port sets the box position, the cursor colours and the pattern bytes. A control byte is reached indirectly: the host first writes its index into the address register, then accesses the indexed data register. The pixel path is one registered pipeline stage with valid/ready on both sides. An input beat is accepted whenever the output register is empty or is being drained in the same cycle. While `out_ready` is low and `out_valid` is high, the output beat is held unchanged and `in_ready` is low, so back-pressure reaches the pixel source directly.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, every host-visible register reads 0. The cursor is therefore hidden and disabled, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted beat appears on `out_rgb` with `out_valid` high one cycle later. While `out_valid && !out_ready`, `out_valid` and `out_rgb` hold.
- R3: The X and Y positions are 12 bits each. Offset 0x0C holds the low byte of X and 0x0D the high nibble of X; offsets 0x0E and 0x0F hold Y in the same way. The position is the bottom-right pixel of the box. A pixel is inside when `pos - size + 1 <= coord <= pos` on both axes.
- R4: When either position is 0, no pixel is overlaid and the output equals the input colour.
- R5: Control bit 6 selects a 64x64 box when set and a 32x32 box when clear. In 32x32 mode, control bits 5:4 choose one of four images, each of which starts at pattern byte `image*256`.
- R6: Pattern bytes are row-major, with the top row first. A row is 16 bytes in 64x64 mode and 8 bytes in 32x32 mode. Each byte holds four pixels, with the leftmost in bits 7:6 and the rightmost in bits 1:0.
- R7: Control bits 1:0 hold the mode. In mode 0 every pixel passes through unchanged. In mode 1, code 0 is transparent and codes 1, 2 and 3 give cursor colours 1, 2 and 3.
- R8: In mode 2, code 0 is transparent and codes 1 and 2 give colours 1 and 2. Code 3 gives the bitwise complement of the input colour.
- R9: In mode 3, codes 0 and 1 are transparent and codes 2 and 3 give colours 1 and 2.
- R10: Writing 0x04 selects a colour index (1 to 3) and restarts at red. Each access to 0x05 moves through red, green and blue in turn; after blue it advances to the next index. Red sits in `out_rgb[23:16]` and blue in `[7:0]`. Index 0 stores nothing.
- R11: The pattern byte address is `{control[3:2], reg 0x00}`. Every read or write of 0x0B uses that address and then increments it. The carry propagates into control bits 3:2, and the address wraps from 1023 to 0.
- R12: Offset 0x0A reaches the control byte only while register 0x00 holds 6. With any other index, writes there are dropped and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe |
| host_re | input | 1 | Read strobe; advances auto-incrementing pointers |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when high with `in_valid` |
| in_x | input | COORD_W | Beam X coordinate |
| in_y | input | COORD_W | Beam Y coordinate |
| in_rgb | input | 24 | Underlying pixel colour, R in bits 23:16 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_rgb | output | 24 | Overlaid pixel colour |

## Verification
The bench builds the block with the default 12-bit coordinates and the full 1024-byte pattern store. The full store lets all four 32x32 images and the whole 64x64 image be filled. It also lets the auto-incrementing pattern pointer wrap from 1023 back to 0 and carry from the low byte into the control bits. Using 12-bit coordinates lets positions near 0 clip the box against the left and top edges, while positions near 4095 test the far corner. Random configurations cover all modes in both box sizes, and directed pixels land exactly on the box edges and one pixel outside them.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CH_W      = 8;
  localparam int RGB_W     = 3 * CH_W;
  localparam int CUR_DIM   = 64;
  localparam int PAT_BYTES = CUR_DIM * CUR_DIM / 4;
  localparam int PAT_AW    = $clog2(PAT_BYTES);
  localparam int BANK_W    = PAT_AW - 8;

  typedef enum logic [1:0] {
    CM_OFF     = 2'd0,
    CM_PALETTE = 2'd1,
    CM_INVERT  = 2'd2,
    CM_WINDOW  = 2'd3
  } cur_mode_e;

  localparam logic [3:0] OFS_PTR    = 4'h0;
  localparam logic [3:0] OFS_CSEL   = 4'h4;
  localparam logic [3:0] OFS_CDAT   = 4'h5;
  localparam logic [3:0] OFS_IDAT   = 4'hA;
  localparam logic [3:0] OFS_PDAT   = 4'hB;
  localparam logic [3:0] OFS_XLO    = 4'hC;
  localparam logic [3:0] OFS_XHI    = 4'hD;
  localparam logic [3:0] OFS_YLO    = 4'hE;
  localparam logic [3:0] OFS_YHI    = 4'hF;
  localparam logic [7:0] CTRL_INDEX = 8'h06;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               host_addr,
  input  logic [7:0]               host_wdata,
  input  logic                     host_we,
  input  logic                     host_re,
  output logic [7:0]               host_rdata,
  output logic                     big,
  output logic [1:0]               img,
  output cur_mode_e                mode,
  output logic [COORD_W-1:0]       pos_x,
  output logic [COORD_W-1:0]       pos_y,
  output logic [2:0][RGB_W-1:0]    colors,
  output logic                     pat_we,
  output logic [PAT_AW-1:0]        pat_addr,
  output logic [7:0]               pat_wdata,
  input  logic [7:0]               pat_rdata
);
  localparam int HI_W = COORD_W - 8;

  logic [7:0]         ptr_q;
  logic [7:0]         ctl_q;
  logic [1:0]         csel_q;
  logic [1:0]         comp_q;
  logic [CH_W-1:0]    col_q [3][3];
  logic [COORD_W-1:0] px_q, py_q;

  logic pat_acc, cdat_acc;
  logic [PAT_AW-1:0] pat_next;

  assign pat_acc  = (host_we || host_re) && (host_addr == OFS_PDAT);
  assign cdat_acc = (host_we || host_re) && (host_addr == OFS_CDAT);
  assign pat_addr = {ctl_q[2 +: BANK_W], ptr_q};
  assign pat_next = pat_addr + PAT_AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ctl_q  <= '0;
      csel_q <= '0;
      comp_q <= '0;
      px_q   <= '0;
      py_q   <= '0;
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          col_q[i][j] <= '0;
    end else begin
      if (host_we) begin
        case (host_addr)
          OFS_PTR:  ptr_q <= host_wdata;
          OFS_CSEL: begin
            csel_q <= host_wdata[1:0];
            comp_q <= 2'd0;
          end
          OFS_CDAT: if (csel_q != 2'd0) col_q[csel_q - 2'd1][comp_q] <= host_wdata;
          OFS_IDAT: if (ptr_q == CTRL_INDEX) ctl_q <= host_wdata;
          OFS_XLO:  px_q[7:0] <= host_wdata;
          OFS_XHI:  px_q[COORD_W-1:8] <= host_wdata[HI_W-1:0];
          OFS_YLO:  py_q[7:0] <= host_wdata;
          OFS_YHI:  py_q[COORD_W-1:8] <= host_wdata[HI_W-1:0];
          default: ;
        endcase
      end
      if (pat_acc) {ctl_q[2 +: BANK_W], ptr_q} <= pat_next;
      if (cdat_acc) begin
        if (comp_q == 2'd2) begin
          comp_q <= 2'd0;
          csel_q <= csel_q + 2'd1;
        end else begin
          comp_q <= comp_q + 2'd1;
        end
      end
    end
  end

  always_comb begin
    case (host_addr)
      OFS_PTR:  host_rdata = ptr_q;
      OFS_CSEL: host_rdata = {6'd0, csel_q};
      OFS_CDAT: host_rdata = (csel_q == 2'd0) ? 8'd0 : col_q[csel_q - 2'd1][comp_q];
      OFS_IDAT: host_rdata = (ptr_q == CTRL_INDEX) ? ctl_q : 8'd0;
      OFS_PDAT: host_rdata = pat_rdata;
      OFS_XLO:  host_rdata = px_q[7:0];
      OFS_XHI:  host_rdata = 8'(px_q[COORD_W-1:8]);
      OFS_YLO:  host_rdata = py_q[7:0];
      OFS_YHI:  host_rdata = 8'(py_q[COORD_W-1:8]);
      default:  host_rdata = 8'd0;
    endcase
  end

  for (genvar g = 0; g < 3; g++) begin : g_pack
    assign colors[g] = {col_q[g][0], col_q[g][1], col_q[g][2]};
  end

  assign big       = ctl_q[6];
  assign img       = ctl_q[5:4];
  assign mode      = cur_mode_e'(ctl_q[1:0]);
  assign pos_x     = px_q;
  assign pos_y     = py_q;
  assign pat_we    = host_we && (host_addr == OFS_PDAT);
  assign pat_wdata = host_wdata;

  // R11: every data-port access steps the combined pattern pointer by one
  a_r11_pat_step: assert property (@(posedge clk) disable iff (!rst_n)
    pat_acc |=> pat_addr == $past(pat_addr) + PAT_AW'(1));

  // R10: after the blue component the colour index advances
  a_r10_blue_advance: assert property (@(posedge clk) disable iff (!rst_n)
    cdat_acc && comp_q == 2'd2 |=> comp_q == 2'd0 && csel_q == $past(csel_q) + 2'd1);

  // R12: control byte is untouched through the wrong index
  a_r12_ctrl_guard: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_addr == OFS_IDAT && ptr_q != CTRL_INDEX |=> $stable(ctl_q));
endmodule

// File: rtl/cursor_pattern_ram.sv
module cursor_pattern_ram #(
  parameter int BYTES = 1024,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    host_rdata,
  input  logic [AW-1:0] pix_addr,
  output logic [7:0]    pix_rdata
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[host_addr] <= wdata;
  end

  assign host_rdata = mem[host_addr];
  assign pix_rdata  = mem[pix_addr];
endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int DIM     = CUR_DIM
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     big,
  input  logic [1:0]               img,
  input  cur_mode_e                mode,
  input  logic [COORD_W-1:0]       pos_x,
  input  logic [COORD_W-1:0]       pos_y,
  input  logic [COORD_W-1:0]       x,
  input  logic [COORD_W-1:0]       y,
  output logic                     hit,
  output logic [2*$clog2(DIM)-3:0] byte_addr,
  output logic [1:0]               slot
);
  localparam int DW = $clog2(DIM);

  logic [COORD_W-1:0] size, dx, dy;
  logic [DW-1:0]      col, row;
  logic               in_x, in_y, shown;

  always_comb begin
    size  = big ? COORD_W'(DIM) : COORD_W'(DIM / 2);
    dx    = pos_x - x;
    dy    = pos_y - y;
    in_x  = (x <= pos_x) && (dx < size);
    in_y  = (y <= pos_y) && (dy < size);
    shown = (pos_x != '0) && (pos_y != '0) && (mode != CM_OFF);
    hit   = shown && in_x && in_y;
    col   = DW'(size - COORD_W'(1) - dx);
    row   = DW'(size - COORD_W'(1) - dy);
    if (big) byte_addr = {row, col[DW-1:2]};
    else     byte_addr = {img, row[DW-2:0], col[DW-2:2]};
    slot  = col[1:0];
  end

  // R4: a zero coordinate never yields a hit
  a_r4_zero_hides: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_x == '0 || pos_y == '0) |-> !hit);

  // R3: a hit never lies right of or below the corner
  a_r3_hit_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (x <= pos_x) && (y <= pos_y));
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
  import cursor_pkg::*;
(
  input  cur_mode_e             mode,
  input  logic                  hit,
  input  logic [1:0]            code,
  input  logic [RGB_W-1:0]      under,
  input  logic [2:0][RGB_W-1:0] colors,
  output logic [RGB_W-1:0]      result
);
  always_comb begin
    result = under;
    if (hit) begin
      case (mode)
        CM_PALETTE: if (code != 2'd0) result = colors[code - 2'd1];
        CM_INVERT: begin
          case (code)
            2'd1:    result = colors[0];
            2'd2:    result = colors[1];
            2'd3:    result = ~under;
            default: result = under;
          endcase
        end
        CM_WINDOW: begin
          if (code == 2'd2)      result = colors[0];
          else if (code == 2'd3) result = colors[1];
        end
        default: result = under;
      endcase
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         host_addr,
  input  logic [7:0]         host_wdata,
  input  logic               host_we,
  input  logic               host_re,
  output logic [7:0]         host_rdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [RGB_W-1:0]   in_rgb,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [RGB_W-1:0]   out_rgb
);
  logic                  big;
  logic [1:0]            img;
  cur_mode_e             mode;
  logic [COORD_W-1:0]    pos_x, pos_y;
  logic [2:0][RGB_W-1:0] colors;
  logic                  pat_we;
  logic [PAT_AW-1:0]     pat_haddr, pat_paddr;
  logic [7:0]            pat_wdata, pat_hdata, pat_pdata;
  logic                  hit;
  logic [1:0]            slot, code;
  logic [RGB_W-1:0]      blended;
  logic                  fire;

  cursor_regs #(.COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .big(big), .img(img), .mode(mode), .pos_x(pos_x), .pos_y(pos_y),
    .colors(colors), .pat_we(pat_we), .pat_addr(pat_haddr),
    .pat_wdata(pat_wdata), .pat_rdata(pat_hdata)
  );

  cursor_pattern_ram #(.BYTES(PAT_BYTES), .AW(PAT_AW)) u_ram (
    .clk(clk), .we(pat_we), .host_addr(pat_haddr), .wdata(pat_wdata),
    .host_rdata(pat_hdata), .pix_addr(pat_paddr), .pix_rdata(pat_pdata)
  );

  cursor_window #(.COORD_W(COORD_W), .DIM(CUR_DIM)) u_win (
    .clk(clk), .rst_n(rst_n),
    .big(big), .img(img), .mode(mode), .pos_x(pos_x), .pos_y(pos_y),
    .x(in_x), .y(in_y), .hit(hit), .byte_addr(pat_paddr), .slot(slot)
  );

  always_comb begin
    case (slot)
      2'd0:    code = pat_pdata[7:6];
      2'd1:    code = pat_pdata[5:4];
      2'd2:    code = pat_pdata[3:2];
      default: code = pat_pdata[1:0];
    endcase
  end

  cursor_blend u_blend (
    .mode(mode), .hit(hit), .code(code), .under(in_rgb),
    .colors(colors), .result(blended)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_rgb   <= blended;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: a stalled output beat holds
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb));

  // R4: hidden cursor passes the input colour through
  a_r4_hidden_pass: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (pos_x == '0 || pos_y == '0) |=> out_rgb == $past(in_rgb));

  // R7: mode 0 passes the input colour through
  a_r7_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode == CM_OFF |=> out_rgb == $past(in_rgb));

  // R8: code 3 in mode 2 complements the input colour
  a_r8_invert: assert property (@(posedge clk) disable iff (!rst_n)
    fire && hit && mode == CM_INVERT && code == 2'd3 |=> out_rgb == ~$past(in_rgb));
endmodule

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [7:0]  host_rdata;
  logic        in_valid = 1'b0, in_ready;
  logic [11:0] in_x = '0, in_y = '0;
  logic [23:0] in_rgb = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [23:0] out_rgb;

  always #2.5 clk = ~clk;

  cursor_overlay u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
    .in_rgb(in_rgb), .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0]  sh_ctl = '0;
  int          sh_px = 0, sh_py = 0;
  logic [23:0] sh_col [1:3];
  logic [7:0]  sh_pat [1024];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL R2 watchdog: got %0d cycles expected fewer than 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hwr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic set_ctl(logic [7:0] v);
    hwr(4'h0, 8'h06);
    hwr(4'hA, v);
    sh_ctl = v;
  endtask

  task automatic set_pos(int x, int y);
    hwr(4'hC, 8'(x)); hwr(4'hD, 8'(x >> 8));
    hwr(4'hE, 8'(y)); hwr(4'hF, 8'(y >> 8));
    sh_px = x; sh_py = y;
  endtask

  task automatic pwr(int a, logic [7:0] d);
    set_ctl({sh_ctl[7:4], 2'(a >> 8), sh_ctl[1:0]});
    hwr(4'h0, 8'(a));
    hwr(4'hB, d);
    sh_pat[a] = d;
    sh_ctl[3:2] = 2'((a + 1) >> 8);
  endtask

  task automatic pix(int x, int y, logic [23:0] c, output logic [23:0] r);
    @(negedge clk);
    in_x = 12'(x); in_y = 12'(y); in_rgb = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 out_valid after accept", 32'(out_valid), 32'd1);
    r = out_rgb;
  endtask

  function automatic logic [23:0] model(int x, int y, logic [23:0] c);
    int size, dx, dy, col, row, bi;
    logic [1:0] code;
    size = sh_ctl[6] ? 64 : 32;
    if (sh_ctl[1:0] == 2'd0 || sh_px == 0 || sh_py == 0) return c;
    if (x > sh_px || y > sh_py) return c;
    dx = sh_px - x; dy = sh_py - y;
    if (dx >= size || dy >= size) return c;
    col = size - 1 - dx; row = size - 1 - dy;
    if (size == 64) bi = row * 16 + col / 4;
    else            bi = int'(sh_ctl[5:4]) * 256 + row * 8 + col / 4;
    code = 2'((sh_pat[bi] >> (6 - 2 * (col % 4))) & 8'h3);
    case (sh_ctl[1:0])
      2'd1: return (code == 0) ? c : sh_col[code];
      2'd2: return (code == 0) ? c : (code == 3) ? ~c : sh_col[code];
      default: return (code < 2) ? c : sh_col[code - 1];
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'd2:    return "R8 mode2";
      2'd3:    return "R9 mode3";
      default: return "R7 mode0/1";
    endcase
  endfunction

  initial begin
    logic [7:0]  rd;
    logic [23:0] res, res2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    hrd(4'hC, rd); chk("R1 pos x low", 32'(rd), 32'd0);
    hrd(4'hF, rd); chk("R1 pos y high", 32'(rd), 32'd0);
    hwr(4'h0, 8'h06); hrd(4'hA, rd); chk("R1 control", 32'(rd), 32'd0);

    // R10: colour loading with auto-advance
    for (int k = 1; k <= 3; k++) sh_col[k] = 24'($urandom);
    hwr(4'h4, 8'd1);
    for (int k = 1; k <= 2; k++) begin
      hwr(4'h5, sh_col[k][23:16]); hwr(4'h5, sh_col[k][15:8]); hwr(4'h5, sh_col[k][7:0]);
    end
    hwr(4'h4, 8'd3);
    hwr(4'h5, sh_col[3][23:16]); hwr(4'h5, sh_col[3][15:8]); hwr(4'h5, sh_col[3][7:0]);
    hwr(4'h4, 8'd2);
    hrd(4'h5, rd); chk("R10 colour2 red", 32'(rd), 32'(sh_col[2][23:16]));
    hrd(4'h5, rd); chk("R10 colour2 green", 32'(rd), 32'(sh_col[2][15:8]));
    hwr(4'h4, 8'd0); hwr(4'h5, 8'hEE);
    hwr(4'h4, 8'd1); hrd(4'h5, rd); chk("R10 index0 dropped", 32'(rd), 32'(sh_col[1][23:16]));

    // R11: fill the whole pattern store through the auto-increment
    set_ctl(8'h00);
    hwr(4'h0, 8'h00);
    for (int i = 0; i < 1024; i++) begin
      sh_pat[i] = 8'($urandom);
      hwr(4'hB, sh_pat[i]);
    end
    hrd(4'h0, rd); chk("R11 pointer wrapped low", 32'(rd), 32'd0);
    hwr(4'h0, 8'h06); hrd(4'hA, rd); chk("R11 bank wrapped", 32'(rd), 32'd0);
    set_ctl(8'h00); hwr(4'h0, 8'hFF);
    hrd(4'hB, rd); chk("R11 read 255", 32'(rd), 32'(sh_pat[255]));
    hrd(4'hB, rd); chk("R11 carry to 256", 32'(rd), 32'(sh_pat[256]));
    set_ctl(8'h0C); hwr(4'h0, 8'hFF);
    hrd(4'hB, rd); chk("R11 read 1023", 32'(rd), 32'(sh_pat[1023]));
    hrd(4'hB, rd); chk("R11 wrap to 0", 32'(rd), 32'(sh_pat[0]));

    // R12: indexed control guard
    set_ctl(8'h41);
    hwr(4'h0, 8'h07); hwr(4'hA, 8'hFF);
    hrd(4'hA, rd); chk("R12 other index reads 0", 32'(rd), 32'd0);
    hwr(4'h0, 8'h06); hrd(4'hA, rd); chk("R12 control kept", 32'(rd), 32'h41);

    // R3 position readback and box edges, R6 leftmost pixel in bits 7:6
    pwr(1023, 8'hFF);
    pwr(1008, 8'hC0);
    set_ctl(8'h41);
    set_pos(2000, 300);
    hrd(4'hD, rd); chk("R3 x high nibble", 32'(rd), 32'h07);
    pix(2000, 300, 24'h123456, res); chk("R3 corner pixel", 32'(res), 32'(sh_col[3]));
    pix(1937, 300, 24'h123456, res); chk("R6 leftmost column", 32'(res), 32'(sh_col[3]));
    pix(1936, 300, 24'h123456, res); chk("R3 one left outside", 32'(res), 32'h123456);
    pix(2001, 300, 24'h123456, res); chk("R3 one right outside", 32'(res), 32'h123456);
    pix(2000, 301, 24'h123456, res); chk("R3 one below outside", 32'(res), 32'h123456);
    pix(2000, 236, 24'h123456, res); chk("R3 one above outside", 32'(res), 32'h123456);

    // R4: zero coordinate hides
    set_pos(100, 0);
    pix(100, 0, 24'hABCDEF, res); chk("R4 y zero hides", 32'(res), 32'hABCDEF);
    set_pos(0, 100);
    pix(0, 100, 24'hABCDEF, res); chk("R4 x zero hides", 32'(res), 32'hABCDEF);

    // R5: 32x32 image select
    pwr(512, 8'h80);
    set_ctl(8'h21);
    set_pos(100, 100);
    pix(69, 69, 24'h0F0F0F, res); chk("R5 image2 top-left", 32'(res), 32'(sh_col[2]));
    pix(68, 69, 24'h0F0F0F, res); chk("R5 32 box left edge", 32'(res), 32'h0F0F0F);

    // R2: back-pressure
    set_ctl(8'h41); set_pos(500, 500);
    out_ready = 1'b0;
    pix(480, 480, 24'h111111, res);
    @(negedge clk);
    in_x = 12'd470; in_y = 12'd490; in_rgb = 24'h222222; in_valid = 1'b1;
    #1 chk("R2 in_ready low while stalled", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R2 held valid", 32'(out_valid), 32'd1);
    chk("R2 held data", 32'(out_rgb), 32'(res));
    chk("R2 first result", 32'(res), 32'(model(480, 480, 24'h111111)));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res2 = out_rgb;
    chk("R2 second after release", 32'(res2), 32'(model(470, 490, 24'h222222)));

    // R7 R8 R9 R5 R6: random configurations
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic [1:0] m, im;
      logic       bg;
      int px, py;
      m  = 2'(cfg % 4);
      bg = 1'((cfg / 4) % 2);
      im = 2'($urandom);
      set_ctl({1'b0, bg, im, 2'b00, m});
      if (cfg >= 8) begin px = $urandom_range(1, 40);  py = $urandom_range(1, 40); end
      else          begin px = $urandom_range(64, 4095); py = $urandom_range(64, 4095); end
      set_pos(px, py);
      for (int n = 0; n < 40; n++) begin
        int x, y;
        logic [23:0] c;
        x = px - int'($urandom_range(0, 70));
        y = py - int'($urandom_range(0, 70));
        if (x < 0) x = $urandom_range(0, 5);
        if (y < 0) y = $urandom_range(0, 5);
        if ($urandom_range(0, 7) == 0 && px < 4095) x = px + 1;
        c = 24'($urandom);
        pix(x, y, c, res);
        chk(mode_tag(m), 32'(res), 32'(model(x, y, c)));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule